// File: doc/BRIEF.md
# Bit-Plane Grayscale Scan Sequencer

This block generates the read-side scan timing for a 1/16-scan LED matrix. The matrix shows 8-bit grayscale by time-sharing the bit planes of each pixel byte. A single pixel clock drives a column counter. When the column counter wraps, the block issues a row latch pulse and advances a row counter. When the row counter wraps, a field counter advances. A frame has 19 fields. The most significant plane is shown in 8 fields, the next plane in 4, the next in 2, and each of the five low planes in 1.

The block outputs several signals:
- A shift clock at the pixel rate.
- The row-select code of the row being displayed.
- A lit enable. Its width in each row period gives that field's weight. The four high planes use the full period and the low planes use halving fractions of it.
- A RAM read address. This address puts the bit-plane index in its three low bits, where the write side keeps the bit index of each byte.

The RAM, the serial data path and the column drivers are outside this block.

Top module: `gray_scan_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the sequencer returns to column 0, row 0, field 0 (plane 7). After that edge `row_latch` is 0, `lit_en` is 0 and `row_sel` is 0.
- R2: The column count (N = 2^COL_BITS columns) advances by one on each rising edge and wraps from N-1 to 0. It appears on `rd_addr[COL_BITS+2:3]`.
- R3: `row_latch` is high exactly in the cycles where the column count is N-1, so it pulses once every N cycles.
- R4: The row count advances by one, modulo 16 for the default width, on the edge that ends a `row_latch` cycle. It appears on the top ROW_BITS bits of `rd_addr`.
- R5: The field counter advances on the edge that ends the latch cycle of the last row. It steps through 19 fields and then starts again. Over those fields `plane_idx` takes 7 eight times, 6 four times, 5 twice, and then 4, 3, 2, 1 and 0 once each.
- R6: `rd_addr` equals {row, column, plane_idx}, with the plane index in bits 2:0.
- R7: `row_sel` is loaded with the row that was just shifted, on the edge that ends each latch cycle. It holds that value for the whole next row period. It stays 0 until the first latch after reset.
- R8: In a row period, the displayed plane p is the plane that was latched at the start of that period. `lit_en` is high at column counts c < W(p), where W = N for p = 4..7 and W = N >> (4 - p) for p = 0..3, with the exception given in R9. `lit_en` is low throughout the first row period after reset.
- R9: `lit_en` is low in every cycle where `row_latch` is high.
- R10: `shift_clk` runs at the input clock frequency. It is low in the first half of each clock period, which starts at the rising edge, and high in the second half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_clk | output | 1 | Serial shift clock, inverted pixel clock |
| row_latch | output | 1 | Row latch pulse in the last column cycle |
| row_sel | output | ROW_BITS | Row code of the displayed row |
| lit_en | output | 1 | Display enable; its width weights the field |
| plane_idx | output | 3 | Bit plane being read |
| rd_addr | output | ROW_BITS+COL_BITS+3 | RAM read address {row, column, plane} |

## Verification
The counters and `rd_addr` are registered, so their values are due one edge after the edge that advances them. The bench models the state after k rising edges since reset release, from k alone. It samples 1 ns after each rising edge, where `shift_clk` is also due low, and checks `shift_clk` high 1 ns after each falling edge. `row_sel` and `lit_en` describe the row period before the current one, so the bench derives them from period k/N - 1. A reduced configuration of 32 columns is swept over more than two full frames, and the sweep is repeated after a reset applied mid-run.

// File: rtl/gray_scan_seq.sv
module gray_scan_seq #(
  parameter int COL_BITS = 10,
  parameter int ROW_BITS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  output logic                         shift_clk,
  output logic                         row_latch,
  output logic [ROW_BITS-1:0]          row_sel,
  output logic                         lit_en,
  output logic [2:0]                   plane_idx,
  output logic [ROW_BITS+COL_BITS+2:0] rd_addr
);
  localparam logic [COL_BITS-1:0] COL_LAST   = '1;
  localparam logic [ROW_BITS-1:0] ROW_LAST   = '1;
  localparam logic [4:0]          FIELD_LAST = 5'd18;

  logic [COL_BITS-1:0] col;
  logic [ROW_BITS-1:0] row;
  logic [4:0]          field;
  logic [2:0]          disp_plane;
  logic                disp_valid;
  logic                end_row, end_field, frac_on;

  function automatic logic [2:0] plane_of(input logic [4:0] f);
    if (f < 5'd8)       return 3'd7;
    else if (f < 5'd12) return 3'd6;
    else if (f < 5'd14) return 3'd5;
    else                return 3'(5'd18 - f);
  endfunction

  assign end_row   = (col == COL_LAST);
  assign end_field = end_row && (row == ROW_LAST);
  assign plane_idx = plane_of(field);
  assign rd_addr   = {row, col, plane_idx};
  assign row_latch = end_row;
  assign shift_clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      col        <= '0;
      row        <= '0;
      field      <= '0;
      row_sel    <= '0;
      disp_plane <= 3'd7;
      disp_valid <= 1'b0;
    end else begin
      col <= col + 1'b1;
      if (end_row) begin
        row        <= row + 1'b1;
        row_sel    <= row;
        disp_plane <= plane_idx;
        disp_valid <= 1'b1;
      end
      if (end_field)
        field <= (field == FIELD_LAST) ? 5'd0 : field + 5'd1;
    end
  end

  always_comb begin
    case (disp_plane)
      3'd3:    frac_on = ~col[COL_BITS-1];
      3'd2:    frac_on = (col[COL_BITS-1 -: 2] == 2'd0);
      3'd1:    frac_on = (col[COL_BITS-1 -: 3] == 3'd0);
      3'd0:    frac_on = (col[COL_BITS-1 -: 4] == 4'd0);
      default: frac_on = 1'b1;
    endcase
  end

  assign lit_en = disp_valid && frac_on && !end_row;
endmodule

// File: rtl/gray_scan_seq_chk.sv
module gray_scan_seq_chk #(
  parameter int COL_BITS = 10,
  parameter int ROW_BITS = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         row_latch,
  input logic [ROW_BITS-1:0]          row_sel,
  input logic                         lit_en,
  input logic [2:0]                   plane_idx,
  input logic [ROW_BITS+COL_BITS+2:0] rd_addr
);
  localparam int RT = ROW_BITS + COL_BITS + 2;

  AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    row_latch |=> !row_latch); // R3
  AST_COL_RESTART: assert property (@(posedge clk) disable iff (rst)
    row_latch |=> (rd_addr[COL_BITS+2:3] == '0)); // R2
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
    row_latch |=> (rd_addr[RT -: ROW_BITS] == ROW_BITS'($past(rd_addr[RT -: ROW_BITS]) + 1'b1))); // R4
  AST_PLANE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(row_latch && rd_addr[RT -: ROW_BITS] == '1) |=> $stable(plane_idx)); // R5
  AST_ADDR_PLANE: assert property (@(posedge clk) disable iff (rst)
    rd_addr[2:0] == plane_idx); // R6
  AST_ROWSEL_LOAD: assert property (@(posedge clk) disable iff (rst)
    row_latch |=> (row_sel == $past(rd_addr[RT -: ROW_BITS]))); // R7
  AST_ROWSEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !row_latch |=> $stable(row_sel)); // R7
  AST_DARK_AT_LATCH: assert property (@(posedge clk) disable iff (rst)
    row_latch |-> !lit_en); // R9
endmodule

bind gray_scan_seq gray_scan_seq_chk #(.COL_BITS(COL_BITS), .ROW_BITS(ROW_BITS)) u_chk (
  .clk(clk), .rst(rst), .row_latch(row_latch), .row_sel(row_sel),
  .lit_en(lit_en), .plane_idx(plane_idx), .rd_addr(rd_addr)
);

// File: tb/sim_gray_scan_seq.sv
`timescale 1ns/1ps
module sim_gray_scan_seq;
  localparam int CB = 5;
  localparam int RB = 4;
  localparam int N  = 1 << CB;
  localparam int ROWS = 1 << RB;
  localparam int FRAME = 19 * ROWS * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_clk, row_latch, lit_en;
  logic [RB-1:0] row_sel;
  logic [2:0] plane_idx;
  logic [RB+CB+2:0] rd_addr;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gray_scan_seq #(.COL_BITS(CB), .ROW_BITS(RB)) u0 (
    .clk(clk), .rst(rst), .shift_clk(shift_clk), .row_latch(row_latch),
    .row_sel(row_sel), .lit_en(lit_en), .plane_idx(plane_idx), .rd_addr(rd_addr)
  );

  function automatic int plane_of(int f);
    if (f < 8) return 7;
    if (f < 12) return 6;
    if (f < 14) return 5;
    return 18 - f;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_state(int k, string tag);
    int col, row, f, p, m, dp, w, elit, erow, eaddr;
    col = k % N;
    row = (k / N) % ROWS;
    f = (k / (N * ROWS)) % 19;
    p = plane_of(f);
    eaddr = (row << (CB + 3)) | (col << 3) | p;
    if (k < N) begin
      elit = 0; erow = 0;
    end else begin
      m = k / N - 1;
      erow = m % ROWS;
      dp = plane_of((m / ROWS) % 19);
      w = (dp >= 4) ? N : (N >> (4 - dp));
      elit = (col < w && col != N - 1) ? 1 : 0;
    end
    chk({tag, " R2/R4/R5/R6 rd_addr"}, int'(rd_addr), eaddr);
    chk({tag, " R5 plane_idx"}, int'(plane_idx), p);
    chk({tag, " R3 row_latch"}, int'(row_latch), (col == N - 1) ? 1 : 0);
    chk({tag, " R7 row_sel"}, int'(row_sel), erow);
    chk({tag, " R8/R9 lit_en"}, int'(lit_en), elit);
    chk({tag, " R10 shift_clk low"}, int'(shift_clk), 0);
  endtask

  task automatic run(int cycles, string tag);
    for (int k = 1; k <= cycles; k++) begin
      @(posedge clk); #1;
      check_state(k, tag);
      @(negedge clk); #1;
      chk({tag, " R10 shift_clk high"}, int'(shift_clk), 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_state(0, "R1 reset");
    @(negedge clk); rst = 1'b0;
    run(2 * FRAME + 3 * N, "sweep");
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check_state(0, "R1 midrun reset");
    @(negedge clk); rst = 1'b0;
    run(ROWS * N * 3 + 5, "after reset");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule